// File: doc/BRIEF.md
# Compare-Match Timer Channel with Toggle Output

This block is one 16-bit timer channel controlled through register write strobes. A programmable divider turns the module clock into count ticks. On every tick the counter is compared with a compare register. A hit can return the counter to zero, so the channel runs with a period of compare+1 ticks. A hit also sets a status flag, which can raise an interrupt, and it can change the level of a compare output pin.

A typical use is a heartbeat that keeps an external supervisor alive while software is busy elsewhere. Software loads the compare value, picks the divider and clear mode, and sets the pin to start high and invert on every hit. It then sets the start bit. The pin keeps toggling with no further software action. Clearing the start bit freezes the count and the pin, so the heartbeat stops and the supervisor sees it stop.

Top module: `ocTimer`

## Requirements
- R1: After reset the count, the compare pin, the match flag and the interrupt request are all 0, and the channel is stopped.
- R2: The prescale field, bits [1:0] of a control write, makes the counter advance once every 4^p clocks while running: 0 gives every clock, 1 gives every 4, 2 gives every 16, and 3 gives every 64 clocks.
- R3: When the clear-select field, bits [7:5] of the control value, is 001, a compare hit returns the counter to zero, so hits come every compare+1 ticks. Any other clear-select code lets the counter run freely and wrap from all-ones to zero.
- R4: A compare hit happens on a tick on which the counter value before the increment equals the compare register.
- R5: A write to the I/O-control register sets the pin, on that clock edge, to bit [2] of the written value, whether or not a hit has occurred.
- R6: On each compare hit, the pin does what I/O-control bits [1:0] select: 00 keeps its level, 01 drives it low, 10 drives it high, 11 inverts it. With code 0111 the pin starts at 1 and toggles on every hit.
- R7: The counter advances only while the start bit (bit 0 of a start write) is 1. Writing 0 stops the count and the pin holds its level. The prescaler restarts from zero on the next start.
- R8: While the mode register (bits [3:0]) holds a nonzero value, the counter does not advance.
- R9: A compare hit sets the match flag. The flag clears only on a status write with bit 0 equal to 0 that follows a status read strobe seen while the flag was 1. A status write of 1, or a status write without such a read, leaves the flag set. A hit on the same edge as a clear keeps the flag set.
- R10: The interrupt request is high exactly when the match flag is set and bit 0 of the interrupt-enable register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrCtrl | input | 1 | Write strobe for clear-select [7:5] and prescale [1:0] |
| wrMode | input | 1 | Write strobe for the mode register [3:0] |
| wrIoCtrl | input | 1 | Write strobe for the pin control: initial level [2], hit action [1:0] |
| wrIntEn | input | 1 | Write strobe for the interrupt enable [0] |
| wrCompare | input | 1 | Write strobe for the compare register |
| wrStart | input | 1 | Write strobe for the start bit [0] |
| wrStatus | input | 1 | Write strobe for the match flag [0] (only 0 clears) |
| rdStatus | input | 1 | Read strobe for the status; arms the flag clear |
| wrData | input | CNT_W | Data for all write strobes |
| count | output | CNT_W | Current counter value |
| cmpPin | output | 1 | Compare output pin |
| matchFlag | output | 1 | Compare-hit status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with an 8-bit counter, so the free-running wrap at 255 is reached in a few hundred ticks. It sweeps every prescale code against compare values 0 to 7 and cycles through all four pin actions. It derives the expected count, the number of hits, the pin level and the flag from the tick count alone. The default 6-bit prescaler is kept, so the divide-by-64 setting is exercised at full length.

// File: rtl/ocTimerPkg.sv
package ocTimerPkg;

  typedef struct packed {
    logic       tick;
    logic       clrOnMatch;
    logic       loadPin;
    logic       pinInit;
    logic [1:0] pinAct;
    logic       loadCmp;
  } dpStrobeT;

  localparam logic [2:0] CLR_ON_CMP = 3'b001;

  localparam logic [1:0] ACT_HOLD   = 2'b00;
  localparam logic [1:0] ACT_LOW    = 2'b01;
  localparam logic [1:0] ACT_HIGH   = 2'b10;
  localparam logic [1:0] ACT_TOGGLE = 2'b11;

endpackage

// File: rtl/ocTimerCtrl.sv
module ocTimerCtrl
  import ocTimerPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_STEP  = 2,
  parameter int PS_CODES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtrl,
  input  logic             wrMode,
  input  logic             wrIoCtrl,
  input  logic             wrIntEn,
  input  logic             wrStart,
  input  logic             wrStatus,
  input  logic             rdStatus,
  input  logic             wrCompare,
  input  logic [CNT_W-1:0] wrData,
  input  logic             matchHit,
  output dpStrobeT         strb,
  output logic             matchFlag,
  output logic             irq
);

  localparam int PRE_W    = PS_STEP * (PS_CODES - 1);
  localparam int PS_SEL_W = (PS_CODES > 1) ? $clog2(PS_CODES) : 1;

  logic [2:0]          clrSel;
  logic [PS_SEL_W-1:0] psSel;
  logic [3:0]          modeReg;
  logic [3:0]          ioCtrl;
  logic                intEn;
  logic                running;
  logic                armed;
  logic [PRE_W-1:0]    preCnt;
  logic [PRE_W:0]      preSpan;
  logic [PRE_W-1:0]    preMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrSel  <= '0;
      psSel   <= '0;
      modeReg <= '0;
      ioCtrl  <= '0;
      intEn   <= 1'b0;
      running <= 1'b0;
    end else begin
      if (wrCtrl) begin
        clrSel <= wrData[7:5];
        psSel  <= wrData[PS_SEL_W-1:0];
      end
      if (wrMode)   modeReg <= wrData[3:0];
      if (wrIoCtrl) ioCtrl  <= wrData[3:0];
      if (wrIntEn)  intEn   <= wrData[0];
      if (wrStart)  running <= wrData[0];
    end
  end

  // prescaler runs only while started, so each start begins a fresh division
  always_ff @(posedge clk) begin
    if (!rstN || !running) preCnt <= '0;
    else                   preCnt <= preCnt + 1'b1;
  end

  assign preSpan = (PRE_W+1)'(1) << (PS_STEP * int'(psSel));
  assign preMask = preSpan[PRE_W-1:0] - PRE_W'(1);

  always_comb begin
    strb.tick       = running && (modeReg == 4'd0) && ((preCnt & preMask) == preMask);
    strb.clrOnMatch = (clrSel == CLR_ON_CMP);
    strb.loadPin    = wrIoCtrl;
    strb.pinInit    = wrData[2];
    strb.pinAct     = ioCtrl[1:0];
    strb.loadCmp    = wrCompare;
  end

  // flag clear needs a prior read that saw the flag set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (matchHit)                           matchFlag <= 1'b1;
      else if (wrStatus && armed && !wrData[0]) matchFlag <= 1'b0;
      if (wrStatus)                     armed <= 1'b0;
      else if (rdStatus && matchFlag)   armed <= 1'b1;
    end
  end

  assign irq = matchFlag & intEn;

endmodule

// File: rtl/ocTimerDp.sv
module ocTimerDp
  import ocTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             cmpPin,
  output logic             matchHit
);

  logic [CNT_W-1:0] cmpReg;

  always_ff @(posedge clk) begin
    if (!rstN)             cmpReg <= '1;
    else if (strb.loadCmp) cmpReg <= wrData;
  end

  // compare against the value before it increments
  assign matchHit = strb.tick && (count == cmpReg);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (strb.tick) begin
      if (matchHit && strb.clrOnMatch) count <= '0;
      else                             count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cmpPin <= 1'b0;
    else if (strb.loadPin) cmpPin <= strb.pinInit;
    else if (matchHit) begin
      case (strb.pinAct)
        ACT_LOW:    cmpPin <= 1'b0;
        ACT_HIGH:   cmpPin <= 1'b1;
        ACT_TOGGLE: cmpPin <= ~cmpPin;
        default:    cmpPin <= cmpPin;
      endcase
    end
  end

endmodule

// File: rtl/ocTimer.sv
module ocTimer
  import ocTimerPkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PS_STEP  = 2,
  parameter int PS_CODES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtrl,
  input  logic             wrMode,
  input  logic             wrIoCtrl,
  input  logic             wrIntEn,
  input  logic             wrCompare,
  input  logic             wrStart,
  input  logic             wrStatus,
  input  logic             rdStatus,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             cmpPin,
  output logic             matchFlag,
  output logic             irq
);

  dpStrobeT strb;
  logic     matchHit;

  ocTimerCtrl #(.CNT_W(CNT_W), .PS_STEP(PS_STEP), .PS_CODES(PS_CODES)) ctrl (
    .clk(clk), .rstN(rstN),
    .wrCtrl(wrCtrl), .wrMode(wrMode), .wrIoCtrl(wrIoCtrl), .wrIntEn(wrIntEn),
    .wrStart(wrStart), .wrStatus(wrStatus), .rdStatus(rdStatus),
    .wrCompare(wrCompare), .wrData(wrData), .matchHit(matchHit),
    .strb(strb), .matchFlag(matchFlag), .irq(irq)
  );

  ocTimerDp #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .count(count), .cmpPin(cmpPin), .matchHit(matchHit)
  );

endmodule

// File: rtl/ocTimerChk.sv
module ocTimerChk
  import ocTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input dpStrobeT         strb,
  input logic             matchHit,
  input logic [CNT_W-1:0] count,
  input logic             cmpPin,
  input logic             matchFlag,
  input logic             irq
);

  a_r7_no_tick_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> $stable(count));

  a_r2_tick_increments: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !matchHit) |=> count == $past(count) + 1'b1);

  a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && strb.clrOnMatch) |=> count == '0);

  a_r9_hit_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> matchFlag);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> matchFlag);

  a_r6_pin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!matchHit && !strb.loadPin) |=> $stable(cmpPin));

  a_r6_pin_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && strb.pinAct == ACT_TOGGLE && !strb.loadPin) |=> cmpPin != $past(cmpPin));

  a_r4_hit_only_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> strb.tick);

endmodule

bind ocTimer ocTimerChk #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .strb(strb), .matchHit(matchHit),
  .count(count), .cmpPin(cmpPin), .matchFlag(matchFlag), .irq(irq)
);

// File: tb/ocTimer_test.sv
module ocTimer_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrCtrl = 0, wrMode = 0, wrIoCtrl = 0, wrIntEn = 0;
  logic         wrCompare = 0, wrStart = 0, wrStatus = 0, rdStatus = 0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] count;
  logic         cmpPin, matchFlag, irq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  ocTimer #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrMode(wrMode), .wrIoCtrl(wrIoCtrl),
    .wrIntEn(wrIntEn), .wrCompare(wrCompare), .wrStart(wrStart), .wrStatus(wrStatus),
    .rdStatus(rdStatus), .wrData(wrData), .count(count), .cmpPin(cmpPin),
    .matchFlag(matchFlag), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; strobe spans exactly one rising edge
  task automatic doWrite(input int which, input int d);
    wrData = W'(d);
    case (which)
      0: wrCtrl    = 1;
      1: wrMode    = 1;
      2: wrIoCtrl  = 1;
      3: wrIntEn   = 1;
      4: wrCompare = 1;
      5: wrStart   = 1;
      6: wrStatus  = 1;
      default: rdStatus = 1;
    endcase
    @(negedge clk);
    {wrCtrl, wrMode, wrIoCtrl, wrIntEn, wrCompare, wrStart, wrStatus, rdStatus} = '0;
  endtask

  task automatic doReset;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 count", count, 0);
    check("R1 pin", cmpPin, 0);
    check("R1 flag", matchFlag, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic runCase(input int clrSel, input int p, input int cmp,
                         input int ioc, input int ie, input int k);
    int d, t, expCnt, m, expPin, initB, act;
    doReset();
    doWrite(4, cmp);
    doWrite(0, (clrSel << 5) | p);
    doWrite(3, ie);
    doWrite(2, ioc);
    initB = (ioc >> 2) & 1;
    check("R5 pin load", cmpPin, initB);
    doWrite(5, 1);
    repeat (k) @(negedge clk);
    doWrite(5, 0);
    d = 1 << (2 * p);
    t = (k + 1) / d;
    if (clrSel == 1) begin
      expCnt = t % (cmp + 1);
      m = t / (cmp + 1);
    end else begin
      expCnt = t % 256;
      m = (t > cmp) ? ((t - 1 - cmp) / 256 + 1) : 0;
    end
    act = ioc & 3;
    case (act)
      1: expPin = (m > 0) ? 0 : initB;
      2: expPin = (m > 0) ? 1 : initB;
      3: expPin = initB ^ (m & 1);
      default: expPin = initB;
    endcase
    check((clrSel == 1) ? "R2 R3 count clear mode" : "R3 R4 count free run", count, expCnt);
    check("R6 pin after hits", cmpPin, expPin);
    check("R9 flag after hits", matchFlag, (m > 0) ? 1 : 0);
    check("R10 irq", irq, (m > 0 && ie == 1) ? 1 : 0);
    repeat (40) @(negedge clk);
    check("R7 count frozen", count, expCnt);
    check("R7 pin frozen", cmpPin, expPin);
  endtask

  initial begin
    @(negedge clk);
    // sweep prescale codes, compare values and pin actions (R2 R3 R4 R6)
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        runCase(1, p, c, ((c + p) & 1) << 2 | (c & 3), c & 1,
                (1 << (2 * p)) * (2 * c + 7) + p);
      end
    end
    // the usual heartbeat setting, 0111
    runCase(1, 1, 5, 7, 1, 150);
    // free-running wrap (R3 R4)
    runCase(0, 0, 3, 7, 1, 700);
    runCase(0, 0, 200, 7, 0, 700);
    runCase(5, 1, 9, 3, 1, 1500);
    runCase(0, 0, 250, 7, 1, 120);

    // R8 nonzero mode holds the counter
    doReset();
    doWrite(4, 3);
    doWrite(0, 8'h20);
    doWrite(1, 1);
    doWrite(5, 1);
    repeat (30) @(negedge clk);
    doWrite(5, 0);
    check("R8 mode holds count", count, 0);
    check("R8 mode no flag", matchFlag, 0);
    doWrite(1, 0);
    doWrite(5, 1);
    repeat (9) @(negedge clk);
    doWrite(5, 0);
    check("R8 mode 0 counts", count, 10 % 4);

    // R9 flag clear protocol, R10 irq follows
    doWrite(3, 1);
    check("R9 flag set before clear", matchFlag, 1);
    doWrite(6, 0);
    check("R9 unarmed write keeps flag", matchFlag, 1);
    doWrite(7, 0);
    doWrite(6, 1);
    check("R9 write one keeps flag", matchFlag, 1);
    check("R10 irq with flag", irq, 1);
    doWrite(7, 0);
    doWrite(6, 0);
    check("R9 armed clear", matchFlag, 0);
    check("R10 irq after clear", irq, 0);
    // R5 load while stopped after hits
    doWrite(2, 4'b0011);
    check("R5 pin load low", cmpPin, 0);
    doWrite(2, 4'b0100);
    check("R5 pin load high", cmpPin, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule